// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places received frames into a circular list of receive descriptors kept in a small internal table. Each entry has a status word, a byte length and a buffer pointer. Software owns an entry until it sets the entry's empty flag. From then on the hardware may fill it. When a frame arrives, the engine writes the length and status of the current entry in one update. It then moves to the next entry. An entry whose wrap flag is set sends the walk back to the ring's base entry.

Frames are modelled only by a byte count and a group of error bits; the data path into the buffers is not part of the block. If the current entry is still owned by software when a frame arrives, the engine drops the frame, raises a busy event and halts. While it is halted, every arriving frame is dropped and counted. Software clears the busy event by writing one to it. It resumes reception with a separate clear-halt strobe. A ring initialisation strobe returns every entry to hardware ownership and moves the walk back to the base entry.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every entry has status 0x20 (empty flag on bit 5, wrap flag on bit 4, error bits 3..0), except the last entry, which has 0x30. Every length and pointer is zero, the current index is 0, and busy, halted and the drop count are 0.
- R2: A frame arriving on an empty current entry is handled in a single update, visible after the next clock edge. The entry's length becomes the byte count plus 4 (the check sequence). Its empty flag clears, its wrap flag is kept, and its error bits take the frame's error bits. frame_done_o pulses with done_idx_o set to that entry.
- R3: After a fill, the index moves to the next entry. After a fill of an entry with the wrap flag, it returns to the base entry instead. Leaving the highest entry without a wrap flag goes to entry 0.
- R4: frame_good_o, which is valid with frame_done_o, is 1 only when all of the frame's error bits are zero.
- R5: A frame arriving at a non-empty current entry is dropped. After the next edge, busy_o and halted_o are 1 and the drop count has gone up. No entry and no index changes.
- R6: While halted, arriving frames change no entry and no index, cause no frame_done_o, and each one adds 1 to the drop count.
- R7: busy_clr_i clears busy_o without leaving the halt. clr_halt_i leaves the halt, and the next frame fills the entry at the unchanged index.
- R8: A write of the base register moves the index to the written entry. ring_init_i puts every entry back to its reset status and zero length, keeps the pointers, and moves the index to the base entry.
- R9: The drop count saturates at its all-ones value.
- R10: A software write stores status, length and pointer of the addressed entry. The read port shows any entry combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_we_i | input | 1 | Write strobe for the ring base entry |
| base_i | input | IDX_W | New base entry index |
| ring_init_i | input | 1 | Return all entries to hardware and index to base |
| sw_we_i | input | 1 | Software descriptor write strobe |
| sw_idx_i | input | IDX_W | Entry addressed by the software write |
| sw_status_i | input | ERR_W+2 | Status word to write |
| sw_len_i | input | LEN_W | Length to write |
| sw_ptr_i | input | PTR_W | Buffer pointer to write |
| rd_idx_i | input | IDX_W | Entry shown on the read port |
| rd_status_o | output | ERR_W+2 | Status of the read entry |
| rd_len_o | output | LEN_W | Length of the read entry |
| rd_ptr_o | output | PTR_W | Pointer of the read entry |
| frame_valid_i | input | 1 | One-cycle frame arrival |
| frame_bytes_i | input | LEN_W | Frame byte count without check sequence |
| frame_err_i | input | ERR_W | Error bits of the frame |
| busy_clr_i | input | 1 | Write-one-to-clear of the busy event |
| clr_halt_i | input | 1 | Leave the halted state |
| frame_done_o | output | 1 | Pulse after a descriptor was filled |
| frame_good_o | output | 1 | Filled frame had no error bits |
| done_idx_o | output | IDX_W | Entry that was filled |
| cur_idx_o | output | IDX_W | Entry the next frame will use |
| busy_o | output | 1 | Busy event |
| halted_o | output | 1 | Reception halted |
| drop_cnt_o | output | DROP_W | Saturating count of dropped frames |

## Verification
A wrong index appears on the first frame after it: the wrong entry loses its empty flag, and done_idx_o and cur_idx_o disagree with the expected walk. The bench compares the whole table after every operation, so such a fault shows within one frame. A wrong ownership or halt decision shows one edge after the frame. Either a fill happens where a drop was due, or busy_o and the drop count stay unchanged. Saturation is driven past its limit, so a counter that wraps shows right at the limit.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_STALL = 2'd2,
    ACT_DROP  = 2'd3
  } ring_act_e;
endpackage

// File: rtl/rx_ring_table.sv
module rx_ring_table #(
  parameter int NUM_DESC = 8,
  parameter int LEN_W    = 16,
  parameter int PTR_W    = 32,
  parameter int ERR_W    = 4,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int STAT_W  = ERR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              hw_we_i,
  input  logic [IDX_W-1:0]  hw_idx_i,
  input  logic [STAT_W-1:0] hw_stat_i,
  input  logic [LEN_W-1:0]  hw_len_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [STAT_W-1:0] sw_stat_i,
  input  logic [LEN_W-1:0]  sw_len_i,
  input  logic [PTR_W-1:0]  sw_ptr_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  output logic [STAT_W-1:0] cur_stat_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [STAT_W-1:0] rd_stat_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [PTR_W-1:0]  rd_ptr_o
);
  logic [STAT_W-1:0] stat_q [NUM_DESC];
  logic [LEN_W-1:0]  len_q  [NUM_DESC];
  logic [PTR_W-1:0]  ptr_q  [NUM_DESC];
  logic [STAT_W-1:0] fresh_stat [NUM_DESC];

  // fresh status: empty, wrap only on the last entry
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_fresh
    assign fresh_stat[g] = {1'b1, (g == NUM_DESC - 1), {ERR_W{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        stat_q[i] <= fresh_stat[i];
        len_q[i]  <= '0;
        ptr_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (init_i) begin
          stat_q[i] <= fresh_stat[i];
          len_q[i]  <= '0;
        end else if (hw_we_i && hw_idx_i == IDX_W'(i)) begin
          stat_q[i] <= hw_stat_i;
          len_q[i]  <= hw_len_i;
        end else if (sw_we_i && sw_idx_i == IDX_W'(i)) begin
          stat_q[i] <= sw_stat_i;
          len_q[i]  <= sw_len_i;
          ptr_q[i]  <= sw_ptr_i;
        end
      end
    end
  end

  assign cur_stat_o = stat_q[cur_idx_i];
  assign rd_stat_o  = stat_q[rd_idx_i];
  assign rd_len_o   = len_q[rd_idx_i];
  assign rd_ptr_o   = ptr_q[rd_idx_i];
endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             init_i,
  input  logic             frame_valid_i,
  input  logic             halted_i,
  input  logic             cur_empty_i,
  input  logic             cur_wrap_i,
  output ring_act_e        act_o,
  output logic [IDX_W-1:0] cur_o
);
  logic [IDX_W-1:0] base_q, cur_q, next_idx;

  always_comb begin
    if (!frame_valid_i)   act_o = ACT_IDLE;
    else if (halted_i)    act_o = ACT_DROP;
    else if (cur_empty_i) act_o = ACT_FILL;
    else                  act_o = ACT_STALL;
  end

  always_comb begin
    if (cur_wrap_i)          next_idx = base_q;
    else if (cur_q == LAST)  next_idx = '0;
    else                     next_idx = cur_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_we_i) base_q <= base_i;
      if (base_we_i)              cur_q <= base_i;
      else if (init_i)            cur_q <= base_q;
      else if (act_o == ACT_FILL) cur_q <= next_idx;
    end
  end

  assign cur_o = cur_q;

  a_r5_index_holds_when_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_i && !base_we_i && !init_i) |=> $stable(cur_q));

  a_r3_wrap_returns_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !halted_i && cur_empty_i && cur_wrap_i && !base_we_i && !init_i)
      |=> cur_q == $past(base_q));
endmodule

// File: rtl/rx_ring_halt.sv
module rx_ring_halt
  import rx_ring_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ring_act_e         act_i,
  input  logic              busy_clr_i,
  input  logic              clr_halt_i,
  output logic              busy_o,
  output logic              halted_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              busy_q, halted_q;
  logic [DROP_W-1:0] drop_q;
  logic              drop_ev;

  assign drop_ev = (act_i == ACT_STALL) || (act_i == ACT_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      halted_q <= 1'b0;
      drop_q   <= '0;
    end else begin
      // set wins over a same-cycle clear
      if (act_i == ACT_STALL) begin
        busy_q   <= 1'b1;
        halted_q <= 1'b1;
      end else begin
        if (busy_clr_i) busy_q   <= 1'b0;
        if (clr_halt_i) halted_q <= 1'b0;
      end
      if (drop_ev && drop_q != '1) drop_q <= drop_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign halted_o   = halted_q;
  assign drop_cnt_o = drop_q;

  a_r9_drop_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q == '1) |=> (drop_q == '1));

  a_r6_drop_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_DROP && drop_q != '1) |=> drop_q == $past(drop_q) + 1'b1);
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int LEN_W    = 16,
  parameter int PTR_W    = 32,
  parameter int ERR_W    = 4,
  parameter int DROP_W   = 8,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int STAT_W  = ERR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic              ring_init_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [STAT_W-1:0] sw_status_i,
  input  logic [LEN_W-1:0]  sw_len_i,
  input  logic [PTR_W-1:0]  sw_ptr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [STAT_W-1:0] rd_status_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [PTR_W-1:0]  rd_ptr_o,
  input  logic              frame_valid_i,
  input  logic [LEN_W-1:0]  frame_bytes_i,
  input  logic [ERR_W-1:0]  frame_err_i,
  input  logic              busy_clr_i,
  input  logic              clr_halt_i,
  output logic              frame_done_o,
  output logic              frame_good_o,
  output logic [IDX_W-1:0]  done_idx_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int EMPTY_B = ERR_W + 1;
  localparam int WRAP_B  = ERR_W;
  localparam logic [LEN_W-1:0] FCS_BYTES = LEN_W'(4);

  ring_act_e         act;
  logic [IDX_W-1:0]  cur_idx;
  logic [STAT_W-1:0] cur_stat, wb_stat;
  logic [LEN_W-1:0]  wb_len;
  logic              fill;
  logic              done_q, good_q;
  logic [IDX_W-1:0]  done_idx_q;

  assign fill    = (act == ACT_FILL);
  assign wb_stat = {1'b0, cur_stat[WRAP_B], frame_err_i};
  assign wb_len  = frame_bytes_i + FCS_BYTES;

  rx_ring_table #(
    .NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .PTR_W(PTR_W), .ERR_W(ERR_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (ring_init_i),
    .hw_we_i    (fill),
    .hw_idx_i   (cur_idx),
    .hw_stat_i  (wb_stat),
    .hw_len_i   (wb_len),
    .sw_we_i    (sw_we_i),
    .sw_idx_i   (sw_idx_i),
    .sw_stat_i  (sw_status_i),
    .sw_len_i   (sw_len_i),
    .sw_ptr_i   (sw_ptr_i),
    .cur_idx_i  (cur_idx),
    .cur_stat_o (cur_stat),
    .rd_idx_i   (rd_idx_i),
    .rd_stat_o  (rd_status_o),
    .rd_len_o   (rd_len_o),
    .rd_ptr_o   (rd_ptr_o)
  );

  rx_ring_walker #(.NUM_DESC(NUM_DESC)) u_walker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .base_we_i     (base_we_i),
    .base_i        (base_i),
    .init_i        (ring_init_i),
    .frame_valid_i (frame_valid_i),
    .halted_i      (halted_o),
    .cur_empty_i   (cur_stat[EMPTY_B]),
    .cur_wrap_i    (cur_stat[WRAP_B]),
    .act_o         (act),
    .cur_o         (cur_idx)
  );

  rx_ring_halt #(.DROP_W(DROP_W)) u_halt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .busy_clr_i (busy_clr_i),
    .clr_halt_i (clr_halt_i),
    .busy_o     (busy_o),
    .halted_o   (halted_o),
    .drop_cnt_o (drop_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      good_q     <= 1'b0;
      done_idx_q <= '0;
    end else begin
      done_q <= fill;
      if (fill) begin
        good_q     <= (frame_err_i == '0);
        done_idx_q <= cur_idx;
      end
    end
  end

  assign frame_done_o = done_q;
  assign frame_good_o = good_q;
  assign done_idx_o   = done_idx_q;
  assign cur_idx_o    = cur_idx;

  a_r2_done_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(frame_valid_i && !halted_o));

  a_r5_busy_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_valid_i));

  a_r6_no_fill_while_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !clr_halt_i) |=> !frame_done_o);
endmodule

// File: tb/rx_desc_ring_tb_top.sv
module rx_desc_ring_tb_top;
  localparam int N      = 8;
  localparam int LEN_W  = 16;
  localparam int PTR_W  = 32;
  localparam int ERR_W  = 4;
  localparam int DROP_W = 8;
  localparam int IDX_W  = 3;
  localparam int STAT_W = 6;
  localparam logic [5:0] EMPTY = 6'h20;
  localparam logic [5:0] WRAP  = 6'h10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic base_we_i = 0, ring_init_i = 0, sw_we_i = 0;
  logic [IDX_W-1:0] base_i = '0, sw_idx_i = '0, rd_idx_i = '0;
  logic [STAT_W-1:0] sw_status_i = '0;
  logic [LEN_W-1:0] sw_len_i = '0, frame_bytes_i = '0;
  logic [PTR_W-1:0] sw_ptr_i = '0;
  logic frame_valid_i = 0, busy_clr_i = 0, clr_halt_i = 0;
  logic [ERR_W-1:0] frame_err_i = '0;
  logic [STAT_W-1:0] rd_status_o;
  logic [LEN_W-1:0] rd_len_o;
  logic [PTR_W-1:0] rd_ptr_o;
  logic frame_done_o, frame_good_o, busy_o, halted_o;
  logic [IDX_W-1:0] done_idx_o, cur_idx_o;
  logic [DROP_W-1:0] drop_cnt_o;

  always #2 clk_i = ~clk_i;

  rx_desc_ring dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [5:0]  m_stat [N];
  logic [15:0] m_len  [N];
  logic [31:0] m_ptr  [N];
  int m_cur = 0, m_base = 0, m_drop = 0;
  bit m_busy = 0, m_halt = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx_i = IDX_W'(i);
      #0.1;
      chk(req, rd_status_o, m_stat[i]);
      chk(req, rd_len_o, m_len[i]);
      chk(req, rd_ptr_o, m_ptr[i]);
    end
    chk(req, cur_idx_o, m_cur);
    chk(req, busy_o, m_busy);
    chk(req, halted_o, m_halt);
    chk(req, drop_cnt_o, m_drop);
  endtask

  function automatic void model_fresh();
    for (int i = 0; i < N; i++) begin
      m_stat[i] = EMPTY | ((i == N - 1) ? WRAP : 6'h0);
      m_len[i]  = 0;
    end
  endfunction

  task automatic send(input string req, input int bytes, input int err, input bit full = 1);
    bit exp_fill = 0;
    int exp_idx = m_cur;
    @(negedge clk_i);
    frame_valid_i = 1; frame_bytes_i = LEN_W'(bytes); frame_err_i = ERR_W'(err);
    if (m_halt) begin
      if (m_drop < 255) m_drop++;
    end else if (m_stat[m_cur][5]) begin
      exp_fill = 1;
      m_stat[m_cur] = (m_stat[m_cur] & WRAP) | 6'(err);
      m_len[m_cur] = 16'(bytes + 4);
      if (m_stat[m_cur][4]) m_cur = m_base;
      else m_cur = (m_cur == N - 1) ? 0 : m_cur + 1;
    end else begin
      m_busy = 1; m_halt = 1;
      if (m_drop < 255) m_drop++;
    end
    @(negedge clk_i);
    frame_valid_i = 0;
    chk(req, frame_done_o, exp_fill);
    if (exp_fill) begin
      chk("R2", done_idx_o, exp_idx);
      chk("R4", frame_good_o, err == 0);
    end
    if (full) check_all(req);
  endtask

  task automatic sw_write(input int idx, input logic [5:0] st, input int len, input int ptr);
    @(negedge clk_i);
    sw_we_i = 1; sw_idx_i = IDX_W'(idx); sw_status_i = st;
    sw_len_i = LEN_W'(len); sw_ptr_i = PTR_W'(ptr);
    m_stat[idx] = st; m_len[idx] = 16'(len); m_ptr[idx] = 32'(ptr);
    @(negedge clk_i);
    sw_we_i = 0;
  endtask

  task automatic base_write(input int v);
    @(negedge clk_i);
    base_we_i = 1; base_i = IDX_W'(v);
    m_base = v; m_cur = v;
    @(negedge clk_i);
    base_we_i = 0;
  endtask

  task automatic ring_init();
    @(negedge clk_i);
    ring_init_i = 1;
    model_fresh(); m_cur = m_base;
    @(negedge clk_i);
    ring_init_i = 0;
  endtask

  task automatic pulse_busy_clr();
    @(negedge clk_i); busy_clr_i = 1; m_busy = 0;
    @(negedge clk_i); busy_clr_i = 0;
  endtask

  task automatic pulse_clr_halt();
    @(negedge clk_i); clr_halt_i = 1; m_halt = 0;
    @(negedge clk_i); clr_halt_i = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_fresh();
    for (int i = 0; i < N; i++) m_ptr[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check_all("R1");

    // R10: software sets pointers, keeps entries empty
    for (int i = 0; i < N; i++)
      sw_write(i, EMPTY | ((i == N - 1) ? WRAP : 6'h0), 0, 32'h1000 + i * 32'h200);
    check_all("R10");

    // R2 R3 R4: fill every entry once, wrap back to base 0
    for (int i = 0; i < N; i++) send("R2", 60 + i * 7, (i % 3 == 0) ? 0 : i);
    chk("R3", cur_idx_o, 0);

    // R5: ring exhausted
    send("R5", 100, 0);
    // R6: frames while halted
    for (int i = 0; i < 3; i++) send("R6", 70 + i, 1);

    // R7: release entries, clear busy only, then resume
    for (int i = 0; i < 3; i++) sw_write(i, EMPTY, 0, 32'h2000 + i);
    pulse_busy_clr();
    check_all("R7");
    send("R7", 80, 0);
    pulse_clr_halt();
    check_all("R7");
    send("R7", 90, 2);
    send("R7", 91, 0);

    // R8: base move and ring init, then wrap to base
    base_write(2);
    check_all("R8");
    ring_init();
    check_all("R8");
    for (int i = 2; i < N; i++) send("R3", 200 + i, 0);
    chk("R3", cur_idx_o, 2);

    // R3: last entry without wrap flag goes to 0
    ring_init();
    sw_write(N - 1, EMPTY, 0, 32'h3333);
    base_write(N - 1);
    send("R3", 64, 0);
    chk("R3", cur_idx_o, 0);

    // R9: force a stall, then overrun the drop counter
    sw_write(0, 6'h00, 5, 32'h44);
    send("R5", 50, 0);
    for (int i = 0; i < 300; i++) send("R9", 40, 0, 0);
    check_all("R9");
    chk("R9", drop_cnt_o, 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule